// File: doc/BRIEF.md
# Character-Row Video Timing Generator

This block produces the raster timing for a display built from character cells. Three counters do the work: a character counter across the line, a raster counter inside a character row, and a row counter down the frame. Each counter is compared against a set of timing values, and the block turns those comparisons into a display window, horizontal and vertical sync, a memory address for the character fetch, and the raster address within the cell. A separate register block holds the timing values and presents them to this block as steady parallel inputs.

After the last character row, a programmable number of extra scanlines trims the frame height. Two interlace modes are supported. In both, the even field is one scanline longer than the odd field, and on the even field the vertical sync starts in the middle of a line. In the sync-and-video mode, the even field shows only even rasters of each cell and the odd field shows only odd rasters, which doubles the vertical resolution. Everything is counted in character clocks: one clock is one character position.

Top module: `charrow_vtg`

## Requirements
- R1: The character counter runs from 0 to `h_total` and then returns to 0, so one scanline lasts `h_total`+1 clocks.
- R2: `de` is high only when all of these hold: the character count is below `h_disp`, the row count is below `v_disp`, and the frame is still in its character rows. `de` is low on every adjust scanline and on the appended interlace scanline.
- R3: `hsync` rises on the clock where the character count equals `h_sync_pos`. It then stays high for exactly `sync_widths[3:0]` clocks, and that pulse can cross into the next line. A width of 0 produces no pulse. A position match while `hsync` is already high is ignored.
- R4: `vsync` starts on raster 0 of the row whose count equals `v_sync_pos`. Without interlace, and on the odd field, it starts on the first clock of that scanline. Its length is N line ends, where N is `sync_widths[7:4]` and a code of 0 means N = 16. It drops on the clock that follows the N-th line end.
- R5: While `vsync` is high, a match of the row count against `v_sync_pos` is ignored, so a running pulse is never restarted or extended.
- R6: `ra` counts from 0 to `max_raster`, and then the row count advances. Once the row count has finished row `v_total`, `v_total_adj` adjust scanlines follow, with `ra` counting 0 upward through them. Then the frame restarts at row 0, raster 0.
- R7: At a frame restart, `ma` and the latched row start both take `start_addr`. `ma` rises by one on each clock whose character count is below `h_disp`, except the last clock of the line. At every line end, `ma` reloads the latched row start. At the end of a row's last raster, the latched row start first takes the current `ma` value. `ma` wraps at 14 bits.
- R8: `ilace_mode` encodings: 00 and 10 select no interlace, 01 selects interlace sync, and 11 selects interlace sync and video. `odd_field` flips at every frame restart when interlace is on, and returns to 0 (even) when it is off. With interlace on, one extra scanline is appended to the even field after the adjust scanlines.
- R9: With interlace on, the even-field `vsync` starts on the clock where the character count equals (`h_total`+1)/2, rounded down.
- R10: In mode 11, `de` can be high only when the low bit of `ra` equals `odd_field`.
- R11: While reset is held, `ma`, `ra` and `odd_field` are 0. `hsync` is low unless `h_sync_pos` is 0, and `vsync` is low unless `v_sync_pos` is 0. After release, counting starts from character 0, raster 0, row 0 on the even field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_total | input | 8 | Characters per line minus one |
| h_disp | input | 8 | Displayed characters per line |
| h_sync_pos | input | 8 | Character count at which hsync starts |
| sync_widths | input | 8 | [3:0] hsync width in clocks, [7:4] vsync width in lines (0 = 16) |
| v_total | input | 7 | Character rows per frame minus one |
| v_total_adj | input | 5 | Adjust scanlines after the last row |
| v_disp | input | 7 | Displayed character rows |
| v_sync_pos | input | 7 | Row count at which vsync starts |
| max_raster | input | 5 | Rasters per character row minus one |
| ilace_mode | input | 2 | Scan mode select |
| start_addr | input | 14 | Memory address of the first character of a frame |
| ma | output | 14 | Character memory address |
| ra | output | 5 | Raster address inside the row |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| odd_field | output | 1 | Current field, 1 = odd |

## Verification
Some behaviour is checked on every clock. Each hsync and vsync segment must have the length captured when it started, counted in clocks or in line ends. `ma` must step by exactly one on each displayed clock that is not a line end. `odd_field` must not rise while interlace is off. Other behaviour only shows up across whole frames, so the bench scenarios cover it: where vsync starts (first clock or mid-line), whether a pulse ignores a row match that arrives too early, the one-line difference between even and odd field lengths, and the raster-parity gating of the display window.

// File: rtl/charrow_pkg.sv
package charrow_pkg;

  // Vertical phase of the frame
  typedef enum logic [1:0] {
    VP_ROWS  = 2'd0,   // character rows
    VP_ADJ   = 2'd1,   // adjust scanlines
    VP_EXTRA = 2'd2    // appended even-field scanline
  } vphase_t;

  function automatic logic ilace_on(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic ilace_video(input logic [1:0] mode);
    return mode == 2'b11;
  endfunction

endpackage

// File: rtl/charrow_hctr.sv
module charrow_hctr #(
  parameter int HW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_sync_pos,
  input  logic [SW-1:0] hs_width,
  output logic [HW-1:0] hcc,
  output logic          line_end,
  output logic          hsync
);

  logic [HW-1:0] hcc_n;
  logic [SW-1:0] hs_left, hs_left_n;
  logic          hs_start;

  always_comb begin
    line_end  = (hcc == h_total);
    hcc_n     = line_end ? '0 : hcc + 1'b1;
    hs_start  = (hcc == h_sync_pos) && (hs_width != '0) && (hs_left == '0);
    hs_left_n = hs_left;
    if (hs_start)
      hs_left_n = hs_width - 1'b1;
    else if (hs_left != '0)
      hs_left_n = hs_left - 1'b1;
    hsync = hs_start || (hs_left != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcc     <= '0;
      hs_left <= '0;
    end else begin
      hcc     <= hcc_n;
      hs_left <= hs_left_n;
    end
  end

endmodule

// File: rtl/charrow_vctr.sv
module charrow_vctr
  import charrow_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 7,
  parameter int RW = 5,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic [HW-1:0] hcc,
  input  logic [HW-1:0] h_total,
  input  logic [RW-1:0] max_raster,
  input  logic [RW-1:0] v_adj,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_sync_pos,
  input  logic [SW-1:0] vs_code,
  input  logic [1:0]    mode,
  output logic [RW-1:0] rcc,
  output logic [VW-1:0] vcc,
  output logic          in_rows,
  output logic          row_last,
  output logic          frame_wrap,
  output logic          field,
  output logic          vsync
);

  localparam int VLW = SW + 1;

  vphase_t        ph, ph_n;
  logic [RW-1:0]  rcc_n;
  logic [VW-1:0]  vcc_n;
  logic           field_n;
  logic           to_extra;
  logic [HW:0]    mid, trig_col;
  logic [VLW-1:0] vs_left, vs_left_n, vs_len;
  logic           vtrig;

  // Sequencing of rasters, rows, adjust and appended lines
  always_comb begin
    ph_n       = ph;
    rcc_n      = rcc;
    vcc_n      = vcc;
    field_n    = field;
    frame_wrap = 1'b0;
    in_rows    = (ph == VP_ROWS);
    row_last   = in_rows && (rcc == max_raster);
    to_extra   = ilace_on(mode) && !field;
    if (line_end) begin
      case (ph)
        VP_ROWS: begin
          if (rcc == max_raster) begin
            if (vcc == v_total) begin
              if (v_adj != '0) begin
                ph_n  = VP_ADJ;
                rcc_n = '0;
              end else if (to_extra) begin
                ph_n  = VP_EXTRA;
                rcc_n = '0;
              end else begin
                frame_wrap = 1'b1;
              end
            end else begin
              vcc_n = vcc + 1'b1;
              rcc_n = '0;
            end
          end else begin
            rcc_n = rcc + 1'b1;
          end
        end
        VP_ADJ: begin
          if (rcc == v_adj - 1'b1) begin
            if (to_extra) begin
              ph_n  = VP_EXTRA;
              rcc_n = '0;
            end else begin
              frame_wrap = 1'b1;
            end
          end else begin
            rcc_n = rcc + 1'b1;
          end
        end
        default: frame_wrap = 1'b1;
      endcase
    end
    if (frame_wrap) begin
      ph_n    = VP_ROWS;
      rcc_n   = '0;
      vcc_n   = '0;
      field_n = ilace_on(mode) ? !field : 1'b0;
    end
  end

  // Vertical sync: first clock or mid-line start, counted in line ends
  always_comb begin
    mid      = ({1'b0, h_total} + 1'b1) >> 1;
    trig_col = (ilace_on(mode) && !field) ? mid : '0;
    vtrig    = in_rows && (rcc == '0) && (vcc == v_sync_pos) &&
               ({1'b0, hcc} == trig_col) && (vs_left == '0);
    vs_len   = (vs_code == '0) ? VLW'(2 ** SW) : {1'b0, vs_code};
    vs_left_n = vs_left;
    if (vtrig)
      vs_left_n = vs_len - {{(VLW-1){1'b0}}, line_end};
    else if (line_end && (vs_left != '0))
      vs_left_n = vs_left - 1'b1;
    vsync = vtrig || (vs_left != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= VP_ROWS;
      rcc     <= '0;
      vcc     <= '0;
      field   <= 1'b0;
      vs_left <= '0;
    end else begin
      ph      <= ph_n;
      rcc     <= rcc_n;
      vcc     <= vcc_n;
      field   <= field_n;
      vs_left <= vs_left_n;
    end
  end

endmodule

// File: rtl/charrow_addr.sv
module charrow_addr #(
  parameter int HW = 8,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcc,
  input  logic [HW-1:0] h_disp,
  input  logic          line_end,
  input  logic          row_last,
  input  logic          frame_wrap,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] ma
);

  logic [AW-1:0] row_base, row_base_n, ma_n;

  always_comb begin
    ma_n       = ma;
    row_base_n = row_base;
    if (line_end) begin
      if (frame_wrap) begin
        ma_n       = start_addr;
        row_base_n = start_addr;
      end else if (row_last) begin
        ma_n       = ma;
        row_base_n = ma;
      end else begin
        ma_n = row_base;
      end
    end else if (hcc < h_disp) begin
      ma_n = ma + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma       <= '0;
      row_base <= '0;
    end else begin
      ma       <= ma_n;
      row_base <= row_base_n;
    end
  end

endmodule

// File: rtl/charrow_vtg.sv
module charrow_vtg
  import charrow_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 7,
  parameter int RW = 5,
  parameter int SW = 4,
  parameter int AW = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HW-1:0]   h_total,
  input  logic [HW-1:0]   h_disp,
  input  logic [HW-1:0]   h_sync_pos,
  input  logic [2*SW-1:0] sync_widths,
  input  logic [VW-1:0]   v_total,
  input  logic [RW-1:0]   v_total_adj,
  input  logic [VW-1:0]   v_disp,
  input  logic [VW-1:0]   v_sync_pos,
  input  logic [RW-1:0]   max_raster,
  input  logic [1:0]      ilace_mode,
  input  logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   ma,
  output logic [RW-1:0]   ra,
  output logic            de,
  output logic            hsync,
  output logic            vsync,
  output logic            odd_field
);

  logic          rst_m, rst_q;
  logic [HW-1:0] hcc;
  logic          line_end;
  logic [RW-1:0] rcc;
  logic [VW-1:0] vcc;
  logic          in_rows, row_last, frame_wrap;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  charrow_hctr #(.HW(HW), .SW(SW)) i_hctr (
    .clk        (clk),
    .rst_n      (rst_q),
    .h_total    (h_total),
    .h_sync_pos (h_sync_pos),
    .hs_width   (sync_widths[SW-1:0]),
    .hcc        (hcc),
    .line_end   (line_end),
    .hsync      (hsync)
  );

  charrow_vctr #(.HW(HW), .VW(VW), .RW(RW), .SW(SW)) i_vctr (
    .clk        (clk),
    .rst_n      (rst_q),
    .line_end   (line_end),
    .hcc        (hcc),
    .h_total    (h_total),
    .max_raster (max_raster),
    .v_adj      (v_total_adj),
    .v_total    (v_total),
    .v_sync_pos (v_sync_pos),
    .vs_code    (sync_widths[2*SW-1:SW]),
    .mode       (ilace_mode),
    .rcc        (rcc),
    .vcc        (vcc),
    .in_rows    (in_rows),
    .row_last   (row_last),
    .frame_wrap (frame_wrap),
    .field      (odd_field),
    .vsync      (vsync)
  );

  charrow_addr #(.HW(HW), .AW(AW)) i_addr (
    .clk        (clk),
    .rst_n      (rst_q),
    .hcc        (hcc),
    .h_disp     (h_disp),
    .line_end   (line_end),
    .row_last   (row_last),
    .frame_wrap (frame_wrap),
    .start_addr (start_addr),
    .ma         (ma)
  );

  assign ra = rcc;
  assign de = (hcc < h_disp) && (vcc < v_disp) && in_rows &&
              (!ilace_video(ilace_mode) || (rcc[0] == odd_field));

endmodule

// File: rtl/charrow_vtg_chk.sv
module charrow_vtg_chk #(
  parameter int AW = 14,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_i,
  input logic          line_end,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [AW-1:0] ma,
  input logic          odd_field,
  input logic [1:0]    ilace_mode,
  input logic [SW-1:0] hs_code,
  input logic [SW-1:0] vs_code
);

  logic          hs_prev, vs_prev;
  logic [SW:0]   hs_cnt, hs_cap;
  logic [SW+1:0] vs_cnt, vs_cap;

  // Segment length trackers; a segment restarts once it has reached its length
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hs_prev <= 1'b0;
      hs_cnt  <= '0;
      hs_cap  <= '0;
      vs_prev <= 1'b0;
      vs_cnt  <= '0;
      vs_cap  <= '0;
    end else begin
      hs_prev <= hsync;
      if (hsync && (!hs_prev || (hs_cnt == hs_cap))) begin
        hs_cap <= {1'b0, hs_code};
        hs_cnt <= {{SW{1'b0}}, 1'b1};
      end else if (hsync) begin
        hs_cnt <= hs_cnt + 1'b1;
      end
      vs_prev <= vsync;
      if (vsync && (!vs_prev || (vs_cnt == vs_cap))) begin
        vs_cap <= (vs_code == '0) ? (SW+2)'(2 ** SW) : {2'b00, vs_code};
        vs_cnt <= {{(SW+1){1'b0}}, line_end};
      end else if (vsync && line_end) begin
        vs_cnt <= vs_cnt + 1'b1;
      end
    end
  end

  assert_hs_width_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (hs_prev && !hsync) |-> (hs_cnt == hs_cap));

  // Also covers R5: a restarted pulse would end with a different count
  assert_vs_lines_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (vs_prev && !vsync) |-> (vs_cnt == vs_cap));

  assert_ma_step_R7: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(rst_i) && $past(de) && !$past(line_end)) |->
      (ma == $past(ma) + {{(AW-1){1'b0}}, 1'b1}));

  assert_field_even_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (!ilace_mode[0] && $past(!ilace_mode[0]) && $past(rst_i) && !$past(odd_field))
      |-> !odd_field);

endmodule

bind charrow_vtg charrow_vtg_chk #(.AW(AW), .SW(SW)) i_chk (
  .clk        (clk),
  .rst_i      (rst_q),
  .line_end   (line_end),
  .hsync      (hsync),
  .vsync      (vsync),
  .de         (de),
  .ma         (ma),
  .odd_field  (odd_field),
  .ilace_mode (ilace_mode),
  .hs_code    (sync_widths[SW-1:0]),
  .vs_code    (sync_widths[2*SW-1:SW])
);

// File: tb/test_charrow_vtg.sv
module test_charrow_vtg;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  r_ht, r_hd, r_hpos, r_sw;
  logic [6:0]  r_vt, r_vd, r_vpos;
  logic [4:0]  r_adj, r_mr;
  logic [1:0]  r_mode;
  logic [13:0] r_start;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic        de, hsync, vsync, odd_field;

  always #(CLK_PERIOD/2) clk = ~clk;

  charrow_vtg i_charrow_vtg (
    .clk(clk), .rst_n(rst_n), .h_total(r_ht), .h_disp(r_hd), .h_sync_pos(r_hpos),
    .sync_widths(r_sw), .v_total(r_vt), .v_total_adj(r_adj), .v_disp(r_vd),
    .v_sync_pos(r_vpos), .max_raster(r_mr), .ilace_mode(r_mode), .start_addr(r_start),
    .ma(ma), .ra(ra), .de(de), .hsync(hsync), .vsync(vsync), .odd_field(odd_field)
  );

  int n_checks = 0;
  int n_errors = 0;

  // Reference state, built from the requirements
  int m_hcc, m_rcc, m_vcc, m_ph, m_field, m_ma, m_row, m_hs, m_vs;
  int e_ma, e_ra, e_de, e_hs, e_vs, e_field;
  // Scenario records
  int vs_first, vs_run, vs_done, fd_rise, fd_fall, de_cnt, de_bad, hs_r1, hs_r2, hs_prev;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ilace();
    return r_mode[0];
  endfunction

  task automatic model_reset();
    m_hcc = 0; m_rcc = 0; m_vcc = 0; m_ph = 0; m_field = 0;
    m_ma = 0; m_row = 0; m_hs = 0; m_vs = 0;
  endtask

  function automatic int hs_start();
    return (m_hcc == r_hpos && r_sw[3:0] != 0 && m_hs == 0) ? 1 : 0;
  endfunction

  function automatic int vs_trig();
    int col;
    col = (ilace() != 0 && m_field == 0) ? (int'(r_ht) + 1) / 2 : 0;
    return (m_ph == 0 && m_rcc == 0 && m_vcc == r_vpos && m_hcc == col && m_vs == 0) ? 1 : 0;
  endfunction

  task automatic model_outputs();
    e_ma    = m_ma;
    e_ra    = m_rcc;
    e_field = m_field;
    e_hs    = (hs_start() != 0 || m_hs != 0) ? 1 : 0;
    e_vs    = (vs_trig() != 0 || m_vs != 0) ? 1 : 0;
    e_de    = (m_hcc < r_hd && m_vcc < r_vd && m_ph == 0 &&
               (r_mode != 2'b11 || (m_rcc % 2) == m_field)) ? 1 : 0;
  endtask

  task automatic model_step();
    int le, hst, vtr, vlen, wrap, rlast, extra;
    le    = (m_hcc == r_ht) ? 1 : 0;
    hst   = hs_start();
    vtr   = vs_trig();
    vlen  = (r_sw[7:4] == 0) ? 16 : int'(r_sw[7:4]);
    rlast = (m_ph == 0 && m_rcc == r_mr) ? 1 : 0;
    extra = (ilace() != 0 && m_field == 0) ? 1 : 0;
    wrap  = 0;
    if (hst != 0) m_hs = r_sw[3:0] - 1;
    else if (m_hs != 0) m_hs--;
    if (vtr != 0) m_vs = vlen - le;
    else if (le != 0 && m_vs != 0) m_vs--;
    if (le != 0) begin
      if (m_ph == 0) begin
        if (m_rcc == r_mr) begin
          if (m_vcc == r_vt) begin
            if (r_adj != 0) begin m_ph = 1; m_rcc = 0; end
            else if (extra != 0) begin m_ph = 2; m_rcc = 0; end
            else wrap = 1;
          end else begin m_vcc++; m_rcc = 0; end
        end else m_rcc++;
      end else if (m_ph == 1) begin
        if (m_rcc == r_adj - 1) begin
          if (extra != 0) begin m_ph = 2; m_rcc = 0; end
          else wrap = 1;
        end else m_rcc++;
      end else wrap = 1;
      if (wrap != 0) begin
        m_ph = 0; m_rcc = 0; m_vcc = 0;
        m_field = (ilace() != 0) ? 1 - m_field : 0;
        m_ma = r_start; m_row = r_start;
      end else if (rlast != 0) m_row = m_ma;
      else m_ma = m_row;
      m_hcc = 0;
    end else begin
      if (m_hcc < r_hd) m_ma = (m_ma + 1) % 16384;
      m_hcc++;
    end
  endtask

  task automatic set_cfg(input int ht, input int hd, input int hpos, input int sw,
                         input int vt, input int adj, input int vd, input int vpos,
                         input int mr, input int mode, input int st);
    r_ht = 8'(ht); r_hd = 8'(hd); r_hpos = 8'(hpos); r_sw = 8'(sw);
    r_vt = 7'(vt); r_adj = 5'(adj); r_vd = 7'(vd); r_vpos = 7'(vpos);
    r_mr = 5'(mr); r_mode = 2'(mode); r_start = 14'(st);
  endtask

  task automatic run_cfg(input int ncyc);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: state while reset is held
    chk(ma == 0, "R11 ma in reset", ma, 0);
    chk(ra == 0, "R11 ra in reset", ra, 0);
    chk(odd_field == 0, "R11 field in reset", odd_field, 0);
    if (r_hpos != 0) chk(hsync == 0, "R11 hsync in reset", hsync, 0);
    if (r_vpos != 0) chk(vsync == 0, "R11 vsync in reset", vsync, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    model_reset();
    vs_first = -1; vs_run = 0; vs_done = 0; fd_rise = -1; fd_fall = -1;
    de_cnt = 0; de_bad = 0; hs_r1 = -1; hs_r2 = -1; hs_prev = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      model_outputs();
      chk(ma == 14'(e_ma), "R7 ma", ma, e_ma);
      chk(ra == 5'(e_ra), "R6 ra", ra, e_ra);
      chk(de == e_de[0], "R2 R10 de", de, e_de);
      chk(hsync == e_hs[0], "R1 R3 hsync", hsync, e_hs);
      chk(vsync == e_vs[0], "R4 R5 R9 vsync", vsync, e_vs);
      chk(odd_field == e_field[0], "R8 field", odd_field, e_field);
      if (vsync) begin
        if (vs_first < 0) vs_first = k;
        if (vs_done == 0) vs_run++;
      end else if (vs_first >= 0) vs_done = 1;
      if (odd_field && fd_rise < 0) fd_rise = k;
      if (!odd_field && fd_rise >= 0 && fd_fall < 0) fd_fall = k;
      if (de) begin
        de_cnt++;
        if (int'(ra[0]) != int'(odd_field)) de_bad++;
      end
      if (hsync && hs_prev == 0) begin
        if (hs_r1 < 0) hs_r1 = k;
        else if (hs_r2 < 0) hs_r2 = k;
      end
      hs_prev = hsync;
      model_step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0;

    // R4 code 0 gives 16 lines; R1 line length from hsync spacing
    set_cfg(9, 5, 2, 8'h03, 4, 0, 3, 0, 3, 0, 16'h0100);
    run_cfg(600);
    chk(vs_first == 0, "R4 vsync start clock", vs_first, 0);
    chk(vs_run == 160, "R4 vsync width code 0", vs_run, 160);
    chk(hs_r2 - hs_r1 == 10, "R1 line length", hs_r2 - hs_r1, 10);

    // R5 two-line frame, three-line pulse: no restart while high
    set_cfg(9, 4, 1, 8'h32, 0, 0, 1, 0, 1, 0, 16'h0000);
    run_cfg(300);
    chk(vs_run == 30, "R5 vsync not retriggered", vs_run, 30);

    // R8 R9 interlace sync: even field six lines, odd five, mid-line start
    set_cfg(9, 6, 7, 8'h24, 1, 1, 2, 0, 1, 1, 16'h2000);
    run_cfg(400);
    chk(vs_first == 5, "R9 mid-line vsync", vs_first, 5);
    chk(fd_rise == 60, "R8 even field length", fd_rise, 60);
    chk(fd_fall == 110, "R8 odd field length", fd_fall - fd_rise, 50);

    // R10 interlace sync and video: raster parity gating
    set_cfg(11, 8, 9, 8'h21, 2, 2, 3, 1, 3, 3, 16'h3FFA);
    run_cfg(800);
    chk(de_bad == 0, "R10 de raster parity", de_bad, 0);
    chk(de_cnt > 0, "R10 de seen", de_cnt, 1);

    // R8 mode 10 behaves as no interlace
    set_cfg(7, 4, 5, 8'h12, 1, 1, 2, 1, 1, 2, 16'h0040);
    run_cfg(400);
    chk(fd_rise < 0, "R8 mode 10 field stays even", fd_rise, -1);

    // Constrained random configurations
    for (int c = 0; c < 12; c++) begin
      int ht, vt;
      ht = $urandom_range(24, 2);
      vt = $urandom_range(5, 0);
      set_cfg(ht, $urandom_range(ht + 2, 1), $urandom_range(ht, 0), $urandom_range(255, 0),
              vt, $urandom_range(3, 0), $urandom_range(vt + 1, 0), $urandom_range(vt, 0),
              $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(16383, 0));
      run_cfg(2500);
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule